// File: doc/BRIEF.md
# Tone Sequence Playback Controller

This block steps through a stored tone sequence. It holds a sequence address that moves forward or backward by one entry per note period. A three-state machine controls it: forward play, hold, and backward play. The machine responds to single-cycle command pulses, which normally come from a button conditioning chain upstream. The note period is a register of clock cycles that can be changed at run time. It can be made shorter or longer in fixed steps, within fixed bounds, and returned to its start-up value.

On every cycle the block drives the current address and the tone period stored at that address. The periods come from a parameterized lookup built inside the block. It also drives a speaker enable and a six-bit indicator that shows which state is active. The tone generator that consumes the period and the enable is not part of this block.

Top module: `tone_seq_player`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters forward play with address 0, the note period at `TEMPO_DEF` and the note cycle counter cleared.
- R2: A play/pause pulse moves forward play or backward play into hold, and moves hold into forward play. When it arrives in the same cycle as a reverse pulse, the play/pause pulse takes priority and the reverse pulse is dropped.
- R3: A reverse pulse swaps forward play and backward play. In hold it has no effect.
- R4: In hold, the address does not move, `spk_en` is 0 and the note counter stays cleared. After hold ends, stepping continues from the held address after a full note period. In both play states `spk_en` is 1.
- R5: In a play state, the address changes at the edge where the note counter has completed the current note period of N cycles. It rises by 1 in forward play and falls by 1 in backward play. Without disturbance, consecutive changes are N cycles apart.
- R6: The address wraps modulo 2^`ADDR_W` in both directions: from the top entry it goes to 0, and from 0 it goes to the top entry.
- R7: A faster pulse subtracts `TEMPO_STEP` from the note period. A slower pulse adds it. A default pulse restores `TEMPO_DEF`. When several arrive together, default wins over faster, and faster wins over slower.
- R8: The note period never goes below `TEMPO_MIN` or above `TEMPO_MAX`. A step that would cross a bound stops at that bound.
- R9: Any faster, slower or default pulse clears the note counter and suppresses the step in that cycle, so the next step comes a full new note period later.
- R10: `led` is one-hot over bits 5..3: bit 5 means forward play, bit 4 means hold, bit 3 means backward play. Bits 2..0 are always 0.
- R11: `tone_period` equals `TONE_BASE + addr * TONE_INC` for the current address, in the same cycle.
- R12: When neither a play/pause pulse nor a reverse pulse is present, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_play_pause | input | 1 | One-cycle pulse: pause or resume |
| cmd_reverse | input | 1 | One-cycle pulse: swap play direction |
| cmd_faster | input | 1 | One-cycle pulse: shorten note period |
| cmd_slower | input | 1 | One-cycle pulse: lengthen note period |
| cmd_tempo_reset | input | 1 | One-cycle pulse: restore default note period |
| rom_addr | output | ADDR_W | Current sequence address |
| tone_period | output | PERIOD_W | Tone period stored at the current address |
| spk_en | output | 1 | Speaker enable, low in hold |
| led | output | 6 | One-hot state indicator |

## Verification
The properties assume that the command inputs are clean, synchronous, single-cycle pulses and that they are only sampled while reset is released. The unit-step property also assumes `TEMPO_MIN` is at least 1, so the address can change by at most one entry per cycle. The stimulus drives each command for exactly one cycle, just after a falling edge. It keeps the period bounds at least one cycle apart, and it deliberately includes same-cycle collisions of play/pause with reverse and of default with faster, because the priorities are defined. A reset in the middle of the run checks that the synchronous clear works from a non-idle state.

// File: rtl/tseq_pkg.sv
// Shared types for the tone sequence playback controller.
// Assumes: the three playback states fit a two-bit code.
package tseq_pkg;

    typedef enum logic [1:0] {
        PS_FWD  = 2'd0,
        PS_HOLD = 2'd1,
        PS_BACK = 2'd2
    } play_st_t;

endpackage

// File: rtl/tseq_fsm.sv
// Playback state machine: forward / hold / backward, driven by pulses.
// Assumes: pulses are synchronous and one cycle wide; play/pause outranks reverse.
module tseq_fsm
    import tseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pp_pulse,
    input  logic     rev_pulse,
    output play_st_t state
);

    play_st_t state_nxt;

    // Next-state decode from the current state and the two command pulses.
    always_comb begin
        state_nxt = state;
        if (pp_pulse) begin
            state_nxt = (state == PS_HOLD) ? PS_FWD : PS_HOLD;
        end else if (rev_pulse) begin
            case (state)
                PS_FWD:  state_nxt = PS_BACK;
                PS_BACK: state_nxt = PS_FWD;
                default: state_nxt = state;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_FWD;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/tseq_tempo.sv
// Note-period register: saturating step up/down, restore-to-default.
// Assumes: TEMPO_MIN <= TEMPO_DEF <= TEMPO_MAX and TEMPO_STEP < 2**TEMPO_W.
module tseq_tempo #(
    parameter int TEMPO_W    = 23,
    parameter int TEMPO_DEF  = 2_000_000,
    parameter int TEMPO_STEP = 200_000,
    parameter int TEMPO_MIN  = 200_000,
    parameter int TEMPO_MAX  = 8_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               faster,
    input  logic               slower,
    input  logic               restore,
    output logic [TEMPO_W-1:0] tempo,
    output logic               tempo_evt
);

    localparam logic [TEMPO_W:0]   STEP_X    = (TEMPO_W+1)'(TEMPO_STEP);
    localparam logic [TEMPO_W:0]   MAX_X     = (TEMPO_W+1)'(TEMPO_MAX);
    localparam logic [TEMPO_W:0]   UP_FLOOR  = (TEMPO_W+1)'(TEMPO_MIN + TEMPO_STEP);
    localparam logic [TEMPO_W-1:0] DEF_V     = TEMPO_W'(TEMPO_DEF);
    localparam logic [TEMPO_W-1:0] MIN_V     = TEMPO_W'(TEMPO_MIN);
    localparam logic [TEMPO_W-1:0] MAX_V     = TEMPO_W'(TEMPO_MAX);

    logic [TEMPO_W:0]   tempo_x;
    logic [TEMPO_W:0]   sum_x;
    logic [TEMPO_W-1:0] tempo_nxt;

    assign tempo_x   = {1'b0, tempo};
    assign sum_x     = tempo_x + STEP_X;
    assign tempo_evt = faster | slower | restore;

    // Saturating update: restore beats faster, faster beats slower.
    always_comb begin
        tempo_nxt = tempo;
        if (restore) begin
            tempo_nxt = DEF_V;
        end else if (faster) begin
            tempo_nxt = (tempo_x < UP_FLOOR) ? MIN_V : TEMPO_W'(tempo_x - STEP_X);
        end else if (slower) begin
            tempo_nxt = (sum_x > MAX_X) ? MAX_V : TEMPO_W'(sum_x);
        end
    end

    // Period register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tempo <= DEF_V;
        else        tempo <= tempo_nxt;
    end

endmodule

// File: rtl/tseq_stepper.sv
// Note counter and wrapping sequence address.
// Assumes: tempo >= 1; counter restarts on tempo change, step or hold.
module tseq_stepper #(
    parameter int TEMPO_W = 23,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               backward,
    input  logic               tempo_evt,
    input  logic [TEMPO_W-1:0] tempo,
    output logic [ADDR_W-1:0]  addr
);

    logic [TEMPO_W-1:0] cnt;
    logic               note_done;

    assign note_done = ({1'b0, cnt} + 1'b1) >= {1'b0, tempo};

    // Per-note cycle counter, cleared by hold, tempo change or a completed note.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tempo_evt || note_done) cnt <= '0;
        else                                          cnt <= cnt + 1'b1;
    end

    // Address register: one entry per completed note, wrapping both ways.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (run && !tempo_evt && note_done) begin
            addr <= backward ? addr - 1'b1 : addr + 1'b1;
        end
    end

endmodule

// File: rtl/tseq_tone_lut.sv
// Tone-period lookup: entry i holds TONE_BASE + i*TONE_INC.
// Assumes: the largest entry fits in PERIOD_W bits.
module tseq_tone_lut #(
    parameter int ADDR_W    = 5,
    parameter int PERIOD_W  = 16,
    parameter int TONE_BASE = 20_000,
    parameter int TONE_INC  = 500
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [PERIOD_W-1:0] period
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [PERIOD_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = PERIOD_W'(TONE_BASE + i * TONE_INC);
    end

    assign period = table_q[addr];

endmodule

// File: rtl/tone_seq_player.sv
// Top level: playback state, note period, address stepper and tone lookup.
// Assumes: command inputs are clean single-cycle synchronous pulses.
module tone_seq_player #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int NOTE_RATE  = 25,
    parameter int TEMPO_DEF  = CLK_HZ / NOTE_RATE,
    parameter int TEMPO_STEP = TEMPO_DEF / 10,
    parameter int TEMPO_MIN  = TEMPO_DEF / 10,
    parameter int TEMPO_MAX  = TEMPO_DEF * 4,
    parameter int ADDR_W     = 5,
    parameter int PERIOD_W   = 16,
    parameter int TONE_BASE  = 20_000,
    parameter int TONE_INC   = 500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_play_pause,
    input  logic                cmd_reverse,
    input  logic                cmd_faster,
    input  logic                cmd_slower,
    input  logic                cmd_tempo_reset,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic [PERIOD_W-1:0] tone_period,
    output logic                spk_en,
    output logic [5:0]          led
);
    import tseq_pkg::*;

    localparam int TEMPO_W = $clog2(TEMPO_MAX + 1);

    play_st_t           state;
    logic [TEMPO_W-1:0] tempo;
    logic               tempo_evt;

    tseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pp_pulse  (cmd_play_pause),
        .rev_pulse (cmd_reverse),
        .state     (state)
    );

    tseq_tempo #(
        .TEMPO_W    (TEMPO_W),
        .TEMPO_DEF  (TEMPO_DEF),
        .TEMPO_STEP (TEMPO_STEP),
        .TEMPO_MIN  (TEMPO_MIN),
        .TEMPO_MAX  (TEMPO_MAX)
    ) u_tempo (
        .clk       (clk),
        .rst_n     (rst_n),
        .faster    (cmd_faster),
        .slower    (cmd_slower),
        .restore   (cmd_tempo_reset),
        .tempo     (tempo),
        .tempo_evt (tempo_evt)
    );

    tseq_stepper #(
        .TEMPO_W (TEMPO_W),
        .ADDR_W  (ADDR_W)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state != PS_HOLD),
        .backward  (state == PS_BACK),
        .tempo_evt (tempo_evt),
        .tempo     (tempo),
        .addr      (rom_addr)
    );

    tseq_tone_lut #(
        .ADDR_W    (ADDR_W),
        .PERIOD_W  (PERIOD_W),
        .TONE_BASE (TONE_BASE),
        .TONE_INC  (TONE_INC)
    ) u_lut (
        .addr   (rom_addr),
        .period (tone_period)
    );

    // Output decode of the state: speaker gate and one-hot indicator.
    always_comb begin
        spk_en = (state != PS_HOLD);
        led    = 6'b000000;
        case (state)
            PS_FWD:  led[5] = 1'b1;
            PS_HOLD: led[4] = 1'b1;
            PS_BACK: led[3] = 1'b1;
            default: led    = 6'b000000;
        endcase
    end

endmodule

// File: rtl/tseq_checker.sv
// Port-level protocol checks for tone_seq_player, attached by bind.
// Assumes: TEMPO_MIN >= 1, so the address moves at most one entry per cycle.
module tseq_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_play_pause,
    input logic              cmd_reverse,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              spk_en,
    input logic [5:0]        led
);

    logic [ADDR_W-1:0] prev_addr;
    logic              prev_vld;

    // Previous-address capture, valid only after one cycle out of reset.
    always_ff @(posedge clk) begin
        prev_addr <= rom_addr;
        prev_vld  <= rst_n;
    end

    AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(led[5:3]) == 1) && (led[2:0] == 3'b000)); // R10

    AST_HOLD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        led[4] |-> !spk_en); // R4

    AST_PLAY_SOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !led[4] |-> spk_en); // R4

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (led[4] && !cmd_play_pause) |=> (led[4] && $stable(rom_addr))); // R4

    AST_REV_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (led[4] && cmd_reverse && !cmd_play_pause) |=> led[4]); // R3

    AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!led[4] && cmd_play_pause) |=> led[4]); // R2

    AST_PAUSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (led[4] && cmd_play_pause) |=> led[5]); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_play_pause && !cmd_reverse) |=> $stable(led)); // R12

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        prev_vld |-> (rom_addr == prev_addr ||
                      rom_addr == prev_addr + 1'b1 ||
                      rom_addr == prev_addr - 1'b1)); // R5

endmodule

bind tone_seq_player tseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_play_pause (cmd_play_pause),
    .cmd_reverse    (cmd_reverse),
    .rom_addr       (rom_addr),
    .spk_en         (spk_en),
    .led            (led)
);

// File: tb/sim_tone_seq_player.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model compared on every falling edge.
module sim_tone_seq_player;

    localparam int ADDR_W   = 3;
    localparam int PERIOD_W = 12;
    localparam int T_DEF    = 20;
    localparam int T_STEP   = 4;
    localparam int T_MIN    = 4;
    localparam int T_MAX    = 40;
    localparam int T_BASE   = 1000;
    localparam int T_INC    = 37;
    localparam int DEPTH    = 1 << ADDR_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [4:0]          cmd = '0; // 0 play/pause, 1 reverse, 2 faster, 3 slower, 4 default
    logic [ADDR_W-1:0]   rom_addr;
    logic [PERIOD_W-1:0] tone_period;
    logic                spk_en;
    logic [5:0]          led;

    int    checks = 0;
    int    failures = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // Reference model state: 0 forward, 1 hold, 2 backward.
    int m_st = 0, m_addr = 0, m_cnt = 0, m_tempo = T_DEF;

    always #10 clk = ~clk;

    tone_seq_player #(
        .TEMPO_DEF (T_DEF), .TEMPO_STEP (T_STEP), .TEMPO_MIN (T_MIN),
        .TEMPO_MAX (T_MAX), .ADDR_W (ADDR_W), .PERIOD_W (PERIOD_W),
        .TONE_BASE (T_BASE), .TONE_INC (T_INC)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .cmd_play_pause (cmd[0]), .cmd_reverse (cmd[1]),
        .cmd_faster (cmd[2]), .cmd_slower (cmd[3]), .cmd_tempo_reset (cmd[4]),
        .rom_addr (rom_addr), .tone_period (tone_period),
        .spk_en (spk_en), .led (led)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_led(input int st);
        return (st == 0) ? 32 : (st == 1) ? 16 : 8;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_cnt = 0; m_tempo = T_DEF;
        end else begin
            bit tev;
            tev = cmd[2] | cmd[3] | cmd[4];
            if (m_st == 1 || tev) m_cnt = 0;
            else if (m_cnt + 1 >= m_tempo) begin
                m_cnt = 0;
                m_addr = (m_st == 2) ? (m_addr + DEPTH - 1) % DEPTH : (m_addr + 1) % DEPTH;
            end else m_cnt++;
            if (cmd[0]) m_st = (m_st == 1) ? 0 : 1;
            else if (cmd[1] && m_st != 1) m_st = (m_st == 0) ? 2 : 0;
            if (cmd[4]) m_tempo = T_DEF;
            else if (cmd[2]) m_tempo = (m_tempo - T_STEP < T_MIN) ? T_MIN : m_tempo - T_STEP;
            else if (cmd[3]) m_tempo = (m_tempo + T_STEP > T_MAX) ? T_MAX : m_tempo + T_STEP;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(phase, "addr", int'(rom_addr), m_addr);
            check("R10", "led", int'(led), exp_led(m_st));
            check("R4", "spk_en", int'(spk_en), (m_st == 1) ? 0 : 1);
            check("R11", "tone_period", int'(tone_period), T_BASE + m_addr * T_INC);
        end
    end

    task automatic apply(input logic [4:0] c);
        @(negedge clk); #1; cmd = c;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; cmd = '0; end
    endtask

    task automatic pulse(input logic [4:0] c, input int gap);
        apply(c); idle(gap);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        check("R1", "reset addr", int'(rom_addr), 0);
        check("R1", "reset led", int'(led), 32);
        #1 rst_n = 1'b1;

        phase = "R5"; idle(90);                      // forward stepping, N=20
        phase = "R6"; idle(100);                     // forward wrap past top entry
        phase = "R3"; pulse(5'b00010, 100);          // backward, wraps below 0
        phase = "R4"; pulse(5'b00001, 50);           // hold
        @(negedge clk);
        check("R4", "held spk_en", int'(spk_en), 0);
        phase = "R3"; pulse(5'b00010, 30);           // reverse ignored in hold
        @(negedge clk);
        check("R3", "still held", int'(led), 16);
        phase = "R2"; pulse(5'b00001, 60);           // resume forward
        @(negedge clk);
        check("R2", "resumed forward", int'(led), 32);
        phase = "R2"; pulse(5'b00011, 30);           // both: play/pause wins
        pulse(5'b00011, 30);
        phase = "R8";
        for (int i = 0; i < 6; i++) pulse(5'b00100, 3);
        idle(40);                                    // saturated at minimum
        for (int i = 0; i < 12; i++) pulse(5'b01000, 2);
        idle(130);                                   // saturated at maximum
        phase = "R7"; pulse(5'b10100, 50);           // default beats faster
        pulse(5'b01100, 50);                         // faster beats slower
        phase = "R9";
        for (int i = 0; i < 8; i++) pulse(5'b10000, 15); // restarts hold off steps
        idle(30);
        phase = "R12"; idle(120);
        @(negedge clk);
        check("R12", "no command keeps state", int'(led), exp_led(m_st));
        phase = "R1"; idle(7);
        #1 rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        check("R1", "mid-run reset addr", int'(rom_addr), 0);
        #1 rst_n = 1'b1;
        idle(45);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule